// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Vote and Noise Event

This block receives asynchronous serial characters from a single line input. An external rate generator supplies a one-cycle enable, `os_tick`, sixteen times per bit period. The line passes through a two-stage synchronizer. A falling level on a tick starts a character. Every bit, including the start and stop bits, is then decided at its centre from three samples taken on ticks 7, 8 and 9 of its sixteen-tick window. A character is one start bit, eight data bits sent least significant bit first, an optional parity bit (even or odd) and one stop bit.

Each finished character is delivered on `rx_data` with a one-cycle `rx_valid` strobe. It is held, with `rx_full` high, until the consumer pulses `rd_ack`. Single-cycle event outputs report these conditions:

- a confirmed start bit;
- a parity mismatch;
- a stop bit read as 0;
- disagreement among the three samples of any bit;
- the beginning and the end of a line break;
- a character lost because the previous one was still unread.

A synchronous-mode input turns off the voting. Each bit is then taken from the tick-8 sample alone, and no noise event is raised.

The controller has six states:

- `ST_IDLE` goes to `ST_START` when a tick sees the line low (start-edge).
- `ST_START` goes back to `ST_IDLE` if the start bit votes high (glitch-reject), or on to `ST_DATA` if it votes low (start-confirm).
- `ST_DATA` goes to `ST_PARITY` or `ST_STOP` after the last data bit (data-done).
- `ST_PARITY` goes to `ST_STOP` (parity-done).
- `ST_STOP` goes to `ST_IDLE` (stop-done). It goes to `ST_BREAK` instead if every bit of the frame, stop bit included, was 0 (break-begin).
- `ST_BREAK` goes to `ST_IDLE` on the first tick that sees the line high (break-end).

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rx_data` is 0x00, and `rx_valid`, `rx_full` and all event outputs are 0.
- R2: A well-formed frame delivers its eight data bits on `rx_data`. The first data bit received becomes bit 0. Delivery is marked by a one-cycle `rx_valid` pulse in the cycle after the stop-bit centre, and `rx_full` rises with it.
- R3: In asynchronous mode (`sync_mode`=0), each bit value is the 2-of-3 majority of the synchronized line sampled at oversample ticks 7, 8 and 9 of the bit. Any single disagreeing sample leaves the received value unchanged.
- R4: In asynchronous mode, `noise_evt` pulses once, alongside the character's completion, when the three samples of any bit of that character (start, data, parity or stop) are not all equal. A clean character gives no pulse.
- R5: With `sync_mode`=1, each bit is the tick-8 sample alone. Flipping the tick-7 sample has no effect, flipping the tick-8 sample changes the bit, and `noise_evt` never pulses.
- R6: With `par_en`=1, a parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity, counted over the data bits plus the parity bit. A mismatch pulses `perr_evt` together with the character's completion.
- R7: `start_evt` pulses once per character, one cycle after the centre of a start bit that votes low.
- R8: A start bit that votes high at its centre is discarded: no `start_evt`, no character and no other event.
- R9: A stop bit that votes 0 pulses `ferr_evt` together with the character's completion.
- R10: `brk_evt` pulses in the same cycle as `ferr_evt` when the whole frame, stop bit included, was 0. It pulses again when the line is next seen high.
- R11: A character completing while `rx_full` is 1 and `rd_ack` is 0 pulses `ovr_evt` instead of `rx_valid`, and `rx_data` keeps the earlier byte. `rd_ack` clears `rx_full`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversample enable, 16 per bit |
| sync_mode | input | 1 | 1: single-sample decision, no noise detection |
| par_en | input | 1 | 1: a parity bit follows the data |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| rd_ack | input | 1 | Consumer has read `rx_data` |
| rx_data | output | 8 | Last accepted character |
| rx_valid | output | 1 | One-cycle pulse on a new character |
| rx_full | output | 1 | Character held and unread |
| start_evt | output | 1 | Start bit confirmed |
| perr_evt | output | 1 | Parity mismatch |
| ferr_evt | output | 1 | Stop bit read as 0 |
| noise_evt | output | 1 | Non-unanimous samples in the character |
| brk_evt | output | 1 | Break began or ended |
| ovr_evt | output | 1 | Character discarded, buffer full |

## Verification
The end-of-character cycle is where most coincidences occur. A break frame makes `ferr_evt` and `brk_evt` fire in the same cycle. The bench drives an all-zero frame whose stop bit is also low and keeps the line low for several more bit periods. It counts the cycles in which both pulses are seen together and expects exactly one, followed later by a lone `brk_evt` when the line goes high. The overrun test makes `ovr_evt` and the suppressed `rx_valid` compete in the same cycle. It is judged by checking that `rx_data` still holds the first byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } rx_state_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxs,
    input  logic restart,
    input  logic active,
    input  logic sync_mode,
    output logic bit_done,
    output logic bit_val,
    output logic bit_noisy
);
    localparam int CW  = $clog2(OS_RATE);
    localparam int MID = OS_RATE / 2;

    logic [CW-1:0] cnt;
    logic          s_early;
    logic          s_mid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            s_early <= 1'b1;
            s_mid   <= 1'b1;
        end else if (tick) begin
            if (restart)
                cnt <= CW'(1);
            else if (cnt == CW'(OS_RATE - 1))
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            if (cnt == CW'(MID - 1)) s_early <= rxs;
            if (cnt == CW'(MID))     s_mid   <= rxs;
        end
    end

    always_comb begin
        bit_done  = active & tick & (cnt == CW'(MID + 1));
        bit_val   = sync_mode ? s_mid : maj3(s_early, s_mid, rxs);
        bit_noisy = ~sync_mode & ~((s_early == s_mid) & (s_mid == rxs));
    end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         ack,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full,
    output logic         ovr
);
    logic blocked;
    assign blocked = full & ~ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
            full  <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            valid <= 1'b0;
            ovr   <= 1'b0;
            if (push && blocked) begin
                ovr <= 1'b1;
            end else if (push) begin
                dout  <= din;
                valid <= 1'b1;
                full  <= 1'b1;
            end else if (ack) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd_in,
    input  logic                 os_tick,
    input  logic                 sync_mode,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rd_ack,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_full,
    output logic                 start_evt,
    output logic                 perr_evt,
    output logic                 ferr_evt,
    output logic                 noise_evt,
    output logic                 brk_evt,
    output logic                 ovr_evt
);
    localparam int BCW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    rx_state_t            state, state_nx;
    logic                 rxs;
    logic                 bit_done, bit_val, bit_noisy;
    logic                 restart, active, push;
    logic [BCW-1:0]       bit_cnt;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_acc, perr_flag, zero_all, noise_acc;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rxd_in),
        .d_out (rxs)
    );

    assign restart = (state == ST_IDLE) & ~rxs;
    assign active  = (state != ST_IDLE) & (state != ST_BREAK);

    uart_rx_sampler #(.OS_RATE(OS_RATE)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rxs       (rxs),
        .restart   (restart),
        .active    (active),
        .sync_mode (sync_mode),
        .bit_done  (bit_done),
        .bit_val   (bit_val),
        .bit_noisy (bit_noisy)
    );

    assign push = (state == ST_STOP) & bit_done;

    uart_rx_hold #(.W(DATA_BITS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (shreg),
        .ack   (rd_ack),
        .dout  (rx_data),
        .valid (rx_valid),
        .full  (rx_full),
        .ovr   (ovr_evt)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (os_tick && !rxs) state_nx = ST_START;
            ST_START:  if (bit_done) state_nx = bit_val ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_done && bit_cnt == BCW'(DATA_BITS - 1))
                           state_nx = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) state_nx = ST_STOP;
            ST_STOP:   if (bit_done) state_nx = (zero_all && !bit_val) ? ST_BREAK : ST_IDLE;
            ST_BREAK:  if (os_tick && rxs) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            perr_flag <= 1'b0;
            zero_all  <= 1'b0;
            noise_acc <= 1'b0;
            start_evt <= 1'b0;
            perr_evt  <= 1'b0;
            ferr_evt  <= 1'b0;
            noise_evt <= 1'b0;
            brk_evt   <= 1'b0;
        end else begin
            start_evt <= 1'b0;
            perr_evt  <= 1'b0;
            ferr_evt  <= 1'b0;
            noise_evt <= 1'b0;
            brk_evt   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (os_tick && !rxs) begin
                        bit_cnt   <= '0;
                        par_acc   <= 1'b0;
                        perr_flag <= 1'b0;
                        zero_all  <= 1'b1;
                        noise_acc <= 1'b0;
                    end
                end
                ST_START: begin
                    if (bit_done) begin
                        noise_acc <= noise_acc | bit_noisy;
                        start_evt <= ~bit_val;
                    end
                end
                ST_DATA: begin
                    if (bit_done) begin
                        shreg     <= {bit_val, shreg[DATA_BITS-1:1]};
                        par_acc   <= par_acc ^ bit_val;
                        zero_all  <= zero_all & ~bit_val;
                        noise_acc <= noise_acc | bit_noisy;
                        bit_cnt   <= bit_cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (bit_done) begin
                        perr_flag <= (par_acc ^ bit_val) != par_odd;
                        zero_all  <= zero_all & ~bit_val;
                        noise_acc <= noise_acc | bit_noisy;
                    end
                end
                ST_STOP: begin
                    if (bit_done) begin
                        ferr_evt  <= ~bit_val;
                        perr_evt  <= perr_flag;
                        noise_evt <= ~sync_mode & (noise_acc | bit_noisy);
                        brk_evt   <= zero_all & ~bit_val;
                    end
                end
                ST_BREAK: begin
                    if (os_tick && rxs) brk_evt <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_mode,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 start_evt,
    input logic                 perr_evt,
    input logic                 ferr_evt,
    input logic                 noise_evt,
    input logic                 brk_evt,
    input logic                 ovr_evt
);
    // R11
    ovr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |-> (!rx_valid && $stable(rx_data)));

    // R5
    sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |=> !noise_evt);

    // R2
    valid_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    perr_with_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_evt |-> (rx_valid || ovr_evt));

    // R10
    brk_begin_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && (rx_valid || ovr_evt)) |-> ferr_evt);

    // R7
    start_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> (!rx_valid && !ovr_evt && !brk_evt));
endmodule

bind uart_os_rx uart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .start_evt (start_evt),
    .perr_evt  (perr_evt),
    .ferr_evt  (ferr_evt),
    .noise_evt (noise_evt),
    .brk_evt   (brk_evt),
    .ovr_evt   (ovr_evt)
);

// File: tb/uart_os_rx_test.sv
module uart_os_rx_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_in = 1'b1;
    logic       os_tick = 1'b0;
    logic       sync_mode = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_full, start_evt, perr_evt, ferr_evt, noise_evt, brk_evt, ovr_evt;
    logic [1:0] divc = 2'd0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int n_valid = 0, n_start = 0, n_perr = 0, n_ferr = 0, n_noise = 0, n_brk = 0, n_ovr = 0, n_fb = 0;
    logic [7:0] last_data = 8'h00;

    uart_os_rx uut (
        .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .os_tick(os_tick),
        .sync_mode(sync_mode), .par_en(par_en), .par_odd(par_odd), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_full(rx_full),
        .start_evt(start_evt), .perr_evt(perr_evt), .ferr_evt(ferr_evt),
        .noise_evt(noise_evt), .brk_evt(brk_evt), .ovr_evt(ovr_evt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        divc    <= divc + 2'd1;
        os_tick <= (divc == 2'd3);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin n_valid++; last_data = rx_data; end
            if (start_evt) n_start++;
            if (perr_evt)  n_perr++;
            if (ferr_evt)  n_ferr++;
            if (noise_evt) n_noise++;
            if (brk_evt)   n_brk++;
            if (ovr_evt)   n_ovr++;
            if (ferr_evt && brk_evt) n_fb++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input bit lvl, input int flip_slot);
        for (int s = 0; s < 16; s++) begin
            @(posedge clk iff os_tick);
            #1 rxd_in = (s == flip_slot) ? ~lvl : lvl;
        end
    endtask

    // bit index: 0 start, 1..8 data, 9 parity (if used), last is stop
    task automatic send_frame(input logic [7:0] d, input bit use_par, input bit par_bit,
                              input bit stop_bit, input int flip_bit, input int flip_slot,
                              input int low_after);
        int idx;
        idx = 0;
        drive_bit(1'b0, (flip_bit == idx) ? flip_slot : -1); idx++;
        for (int i = 0; i < 8; i++) begin
            drive_bit(d[i], (flip_bit == idx) ? flip_slot : -1); idx++;
        end
        if (use_par) begin
            drive_bit(par_bit, (flip_bit == idx) ? flip_slot : -1); idx++;
        end
        drive_bit(stop_bit, (flip_bit == idx) ? flip_slot : -1);
        for (int i = 0; i < low_after; i++) drive_bit(1'b0, -1);
        for (int i = 0; i < 3; i++) drive_bit(1'b1, -1);
    endtask

    task automatic ack_pulse();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rx_data",  int'(rx_data), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 rx_full",  int'(rx_full), 0);
        chk("R1 events",   int'({start_evt, perr_evt, ferr_evt, noise_evt, brk_evt, ovr_evt}), 0);
    endtask

    task automatic t_clean();
        int v0, s0, n0;
        v0 = n_valid; s0 = n_start; n0 = n_noise;
        send_frame(8'hA5, 0, 0, 1, -1, -1, 0);
        chk("R2 valid count", n_valid - v0, 1);
        chk("R2 data LSB first", int'(last_data), 'hA5);
        chk("R2 rx_full", int'(rx_full), 1);
        chk("R7 start count", n_start - s0, 1);
        chk("R4 clean no noise", n_noise - n0, 0);
        ack_pulse();
        @(negedge clk);
        chk("R11 ack clears full", int'(rx_full), 0);
    endtask

    task automatic t_noise_async();
        int n0;
        n0 = n_noise;
        send_frame(8'h3C, 0, 0, 1, 3, 8, 0);
        chk("R3 majority keeps data", int'(last_data), 'h3C);
        chk("R4 noise count", n_noise - n0, 1);
        ack_pulse();
        n0 = n_noise;
        send_frame(8'h81, 0, 0, 1, 0, 7, 0);
        chk("R3 start sample flip", int'(last_data), 'h81);
        chk("R4 noise on start bit", n_noise - n0, 1);
        ack_pulse();
    endtask

    task automatic t_sync_mode();
        int n0;
        sync_mode = 1'b1;
        n0 = n_noise;
        send_frame(8'h00, 0, 0, 1, 1, 7, 0);
        chk("R5 tick7 flip ignored", int'(last_data), 'h00);
        chk("R5 no noise", n_noise - n0, 0);
        ack_pulse();
        send_frame(8'h00, 0, 0, 1, 1, 8, 0);
        chk("R5 tick8 flip decides", int'(last_data), 'h01);
        chk("R5 no noise again", n_noise - n0, 0);
        ack_pulse();
        sync_mode = 1'b0;
    endtask

    task automatic t_parity();
        int p0;
        par_en = 1'b1;
        par_odd = 1'b0;
        p0 = n_perr;
        send_frame(8'h96, 1, ^8'h96, 1, -1, -1, 0);
        chk("R6 even ok", n_perr - p0, 0);
        chk("R6 even data", int'(last_data), 'h96);
        ack_pulse();
        send_frame(8'h96, 1, ~^8'h96, 1, -1, -1, 0);
        chk("R6 even mismatch", n_perr - p0, 1);
        ack_pulse();
        par_odd = 1'b1;
        p0 = n_perr;
        send_frame(8'h07, 1, ~^8'h07, 1, -1, -1, 0);
        chk("R6 odd ok", n_perr - p0, 0);
        ack_pulse();
        send_frame(8'h07, 1, ^8'h07, 1, -1, -1, 0);
        chk("R6 odd mismatch", n_perr - p0, 1);
        ack_pulse();
        par_en = 1'b0;
        par_odd = 1'b0;
    endtask

    task automatic t_glitch();
        int v0, s0, f0;
        v0 = n_valid; s0 = n_start; f0 = n_ferr;
        for (int s = 0; s < 16; s++) begin
            @(posedge clk iff os_tick);
            #1 rxd_in = (s < 4) ? 1'b0 : 1'b1;
        end
        for (int i = 0; i < 12; i++) drive_bit(1'b1, -1);
        chk("R8 no start", n_start - s0, 0);
        chk("R8 no char", n_valid - v0, 0);
        chk("R8 no ferr", n_ferr - f0, 0);
    endtask

    task automatic t_framing();
        int f0, b0, s0;
        f0 = n_ferr; b0 = n_brk; s0 = n_start;
        send_frame(8'h55, 0, 0, 0, -1, -1, 0);
        chk("R9 ferr", n_ferr - f0, 1);
        chk("R9 no break", n_brk - b0, 0);
        chk("R9 single start", n_start - s0, 1);
        chk("R9 data", int'(last_data), 'h55);
        ack_pulse();
    endtask

    task automatic t_break();
        int f0, b0, fb0;
        f0 = n_ferr; b0 = n_brk; fb0 = n_fb;
        send_frame(8'h00, 0, 0, 0, -1, -1, 3);
        chk("R10 ferr", n_ferr - f0, 1);
        chk("R10 begin with ferr", n_fb - fb0, 1);
        chk("R10 begin and end", n_brk - b0, 2);
        ack_pulse();
    endtask

    task automatic t_overrun();
        int v0, o0;
        v0 = n_valid; o0 = n_ovr;
        send_frame(8'h11, 0, 0, 1, -1, -1, 0);
        send_frame(8'h22, 0, 0, 1, -1, -1, 0);
        chk("R11 ovr count", n_ovr - o0, 1);
        chk("R11 one valid", n_valid - v0, 1);
        chk("R11 data kept", int'(rx_data), 'h11);
        ack_pulse();
        send_frame(8'h33, 0, 0, 1, -1, -1, 0);
        chk("R11 after ack", int'(rx_data), 'h33);
        chk("R11 no further ovr", n_ovr - o0, 1);
        ack_pulse();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        repeat (20) @(negedge clk);
        t_clean();
        t_noise_async();
        t_sync_mode();
        t_parity();
        t_glitch();
        t_framing();
        t_break();
        t_overrun();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule